// File: doc/BRIEF.md
# Serial Channel Register Front End

This block is the host-facing register set of one channel of a two-channel UART. It sits on a byte-wide bus and decodes reads and writes inside the channel's eight-address window. Mode settings go to three mode registers (MR0, MR1, MR2) through a single address, reached by a pointer that steps forward on each access. The command register carries receiver and transmitter enable/disable bits and a 4-bit command field that runs one-shot actions.

The block keeps a small receive FIFO, filled by the deserializer, and a one-byte transmit holding register, drained by the serializer. From these it builds the status byte, with sticky error flags. Word length, parity, stop-bit count, MR0 options and the clock-select byte are exported as static outputs. The serializer, the deserializer and the baud generator stay outside the block. They connect through the `rx_*` and `tx_*` ports.

Top module: `uart_chan_regs`

## Requirements
- R1: The channel address offsets are fixed. Offset 0 is the mode register selected by the pointer. Offset 1 reads status and writes the clock-select byte, which drives `clk_sel` and leaves status unchanged. Offset 2 writes the command register. Offset 3 reads the oldest received byte, removing it from the FIFO, and writes the transmit holding register. Reading offset 3 while the FIFO is empty returns 0.
- R2: In a command write, bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. If a bit and its opposite are both set, the disable wins. After reset both are disabled.
- R3: The mode pointer starts at MR1 after reset. Command code 1 sets it to MR1 and code 0xB sets it to MR0. Each read or write of offset 0 moves it MR0→MR1→MR2, and once at MR2 it stays there.
- R4: MR1[1:0] gives `data_bits` (0..3 meaning 5..8 bits). MR1[4:2] gives `parity_sel` (0 even, 1 odd, 4 none).
- R5: `two_stop` is 1 exactly when MR2[3:0] equals 0xF. The value 0x7 means one stop bit.
- R6: MR0[3] drives `fifo_deep`, MR0[4] drives `tx_half`, and MR0[2:0] drives `baud_mode`.
- R7: The status bits, from bit 0 up, are: receive ready, FIFO full, transmit ready (transmitter enabled and holding register empty), transmitter empty (holding register empty and `tx_idle`), overrun, parity error, framing error, received break. After reset status reads 0x08 when `tx_idle` is 1.
- R8: While the receiver is enabled, an `rx_push` stores `rx_byte`. The FIFO holds RX_DEPTH bytes and hands them back in arrival order. While the receiver is disabled, pushes are ignored.
- R9: A push into a full FIFO drops the byte and sets overrun. Overrun stays set until command 4.
- R10: A stored byte that arrives with `rx_perr`, `rx_ferr` or `rx_break` sets the matching sticky status flag. Command 4 clears all four error flags.
- R11: Command 2 empties the receive FIFO and does not touch the error flags. Command 3 discards the transmit holding byte, so transmit ready and transmitter empty return.
- R12: Command 6 sets `break_on` and command 7 clears it. `brk_chg` is set when `rx_break` changes while the receiver is enabled, and command 5 clears it.
- R13: A write to offset 3 loads the holding register only when the transmitter is enabled and the register is empty. `tx_valid` then shows the byte on `tx_data` until `tx_pop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Offset within the channel window |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data (combinational) |
| rx_push | input | 1 | Deserializer delivers a byte |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error on the delivered byte |
| rx_ferr | input | 1 | Framing error on the delivered byte |
| rx_break | input | 1 | Break level seen on the line |
| tx_pop | input | 1 | Serializer takes the holding byte |
| tx_idle | input | 1 | Serializer shift register empty |
| tx_valid | output | 1 | Holding byte available to the serializer |
| tx_data | output | 8 | Holding byte |
| rx_enabled | output | 1 | Receiver enable state |
| tx_enabled | output | 1 | Transmitter enable state |
| data_bits | output | 2 | Word length code |
| parity_sel | output | 3 | Parity mode code |
| two_stop | output | 1 | Two stop bits selected |
| fifo_deep | output | 1 | Deep FIFO option |
| tx_half | output | 1 | Half-full transmit threshold option |
| baud_mode | output | 3 | Baud mode set |
| clk_sel | output | 8 | Clock-select byte |
| break_on | output | 1 | Transmit break active |
| brk_chg | output | 1 | Break change indication |

## Verification
The bench targets the pointer walk. If the pointer wraps instead of holding at MR2, a third mode write corrupts the word length. If a read does not advance it, the readback of MR2 returns MR1. The bench fills the FIFO past its depth: a FIFO that stores the extra byte returns it on read, and an overrun that clears itself shows as a clean status byte. The bench also sends combined enable-and-disable commands, and writes to a disabled receiver and transmitter. A design that favours enable, or accepts data while disabled, changes the status byte or `tx_valid`. Receiver reset is checked with error flags pending, so that a reset that also wipes the errors is caught.

// File: rtl/uart_chan_regs.sv
module uart_chan_regs #(
  parameter int RX_DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rx_push,
  input  logic [7:0] rx_byte,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  input  logic       rx_break,
  input  logic       tx_pop,
  input  logic       tx_idle,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       rx_enabled,
  output logic       tx_enabled,
  output logic [1:0] data_bits,
  output logic [2:0] parity_sel,
  output logic       two_stop,
  output logic       fifo_deep,
  output logic       tx_half,
  output logic [2:0] baud_mode,
  output logic [7:0] clk_sel,
  output logic       break_on,
  output logic       brk_chg
);
  localparam int PW = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam int CW = $clog2(RX_DEPTH + 1);
  localparam logic [3:0] C_PTR1 = 4'h1, C_RXRST = 4'h2, C_TXRST = 4'h3,
                         C_CLRERR = 4'h4, C_CLRBRK = 4'h5, C_BRKON = 4'h6,
                         C_BRKOFF = 4'h7, C_PTR0 = 4'hB;

  logic [1:0] mode_ptr;
  logic [7:0] mr0, mr1, mr2;
  logic [7:0] fifo [RX_DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] rx_cnt;
  logic ovr_q, pe_q, fe_q, brk_q, brk_in_q, hold_v;
  logic [7:0] status;

  wire wr_mode = wr_en && addr == 3'd0;
  wire rd_mode = rd_en && addr == 3'd0;
  wire wr_cmd  = wr_en && addr == 3'd2;
  wire wr_thr  = wr_en && addr == 3'd3;
  wire [3:0] cmd = wr_cmd ? wdata[7:4] : 4'h0;

  wire fifo_full = rx_cnt == CW'(RX_DEPTH);
  wire rx_pop    = rd_en && addr == 3'd3 && rx_cnt != '0;
  wire push_en   = rx_push && rx_enabled;
  wire accept    = push_en && (!fifo_full || rx_pop);
  wire overflow  = push_en && fifo_full && !rx_pop;
  wire rx_flush  = cmd == C_RXRST;
  wire err_clr   = cmd == C_CLRERR;

  assign data_bits  = mr1[1:0];
  assign parity_sel = mr1[4:2];
  assign two_stop   = mr2[3:0] == 4'hF;
  assign fifo_deep  = mr0[3];
  assign tx_half    = mr0[4];
  assign baud_mode  = mr0[2:0];
  assign tx_valid   = hold_v && tx_enabled;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_ptr <= 2'd1;
      mr0 <= '0; mr1 <= '0; mr2 <= '0;
      clk_sel <= '0;
      rx_enabled <= 1'b0;
      tx_enabled <= 1'b0;
      break_on <= 1'b0;
    end else begin
      if (cmd == C_PTR1) mode_ptr <= 2'd1;
      else if (cmd == C_PTR0) mode_ptr <= 2'd0;
      else if ((wr_mode || rd_mode) && mode_ptr != 2'd2) mode_ptr <= mode_ptr + 2'd1;
      if (wr_mode) begin
        case (mode_ptr)
          2'd0:    mr0 <= wdata;
          2'd1:    mr1 <= wdata;
          default: mr2 <= wdata;
        endcase
      end
      if (wr_en && addr == 3'd1) clk_sel <= wdata;
      if (wr_cmd) begin
        if (wdata[1]) rx_enabled <= 1'b0;
        else if (wdata[0]) rx_enabled <= 1'b1;
        if (wdata[3]) tx_enabled <= 1'b0;
        else if (wdata[2]) tx_enabled <= 1'b1;
      end
      if (cmd == C_BRKON) break_on <= 1'b1;
      else if (cmd == C_BRKOFF) break_on <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) fifo[wp] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rx_flush) begin
      wp <= '0; rp <= '0; rx_cnt <= '0;
    end else begin
      if (accept) wp <= (wp == PW'(RX_DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rx_pop) rp <= (rp == PW'(RX_DEPTH - 1)) ? '0 : rp + 1'b1;
      if (accept && !rx_pop) rx_cnt <= rx_cnt + 1'b1;
      else if (!accept && rx_pop) rx_cnt <= rx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_q <= 1'b0; pe_q <= 1'b0; fe_q <= 1'b0; brk_q <= 1'b0;
      brk_in_q <= 1'b0; brk_chg <= 1'b0;
    end else begin
      if (err_clr) begin
        ovr_q <= 1'b0; pe_q <= 1'b0; fe_q <= 1'b0; brk_q <= 1'b0;
      end else begin
        if (overflow) ovr_q <= 1'b1;
        if (accept && rx_perr) pe_q <= 1'b1;
        if (accept && rx_ferr) fe_q <= 1'b1;
        if (accept && rx_break) brk_q <= 1'b1;
      end
      brk_in_q <= rx_break;
      if (cmd == C_CLRBRK) brk_chg <= 1'b0;
      else if (rx_enabled && rx_break != brk_in_q) brk_chg <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cmd == C_TXRST) begin
      hold_v <= 1'b0;
      tx_data <= '0;
    end else if (wr_thr && tx_enabled && !hold_v) begin
      hold_v <= 1'b1;
      tx_data <= wdata;
    end else if (tx_pop && tx_valid) begin
      hold_v <= 1'b0;
    end
  end

  assign status = {brk_q, fe_q, pe_q, ovr_q, !hold_v && tx_idle,
                   tx_enabled && !hold_v, fifo_full, rx_cnt != '0};

  always_comb begin
    case (addr)
      3'd0:    rdata = (mode_ptr == 2'd0) ? mr0 : (mode_ptr == 2'd1) ? mr1 : mr2;
      3'd1:    rdata = status;
      3'd3:    rdata = (rx_cnt != '0) ? fifo[rp] : 8'h00;
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/uart_chan_regs_chk.sv
module uart_chan_regs_chk #(
  parameter int RX_DEPTH = 3
) (
  input logic clk,
  input logic rst_n,
  input logic [2:0] addr,
  input logic wr_en,
  input logic [7:0] wdata,
  input logic [1:0] mode_ptr,
  input logic [$clog2(RX_DEPTH + 1)-1:0] rx_cnt,
  input logic ovr_q,
  input logic rx_enabled,
  input logic tx_valid
);
  wire cmd_w = wr_en && addr == 3'd2;

  // R9
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !(cmd_w && wdata[7:4] == 4'h4)) |=> ovr_q);

  // R2
  dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && wdata[1:0] == 2'b11) |=> !rx_enabled);

  // R11
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && wdata[7:4] == 4'h2) |=> rx_cnt == '0);

  // R11
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && wdata[7:4] == 4'h3) |=> !tx_valid);

  // R3
  ptr_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && mode_ptr == 2'd2) |=> mode_ptr == 2'd2);

  // R8
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= ($clog2(RX_DEPTH + 1))'(RX_DEPTH));
endmodule

bind uart_chan_regs uart_chan_regs_chk #(.RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .mode_ptr(mode_ptr), .rx_cnt(rx_cnt), .ovr_q(ovr_q),
  .rx_enabled(rx_enabled), .tx_valid(tx_valid)
);

// File: tb/tb_uart_chan_regs.sv
module tb_uart_chan_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 0, rd_en = 0, rx_push = 0, rx_perr = 0, rx_ferr = 0, rx_break = 0;
  logic tx_pop = 0, tx_idle = 1;
  logic [7:0] wdata = '0, rx_byte = '0;
  logic [7:0] rdata, tx_data, clk_sel;
  logic tx_valid, rx_enabled, tx_enabled, two_stop, fifo_deep, tx_half, break_on, brk_chg;
  logic [1:0] data_bits;
  logic [2:0] parity_sel, baud_mode;
  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  uart_chan_regs dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rx_push(rx_push), .rx_byte(rx_byte),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_break(rx_break),
    .tx_pop(tx_pop), .tx_idle(tx_idle), .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_enabled(rx_enabled), .tx_enabled(tx_enabled), .data_bits(data_bits),
    .parity_sel(parity_sel), .two_stop(two_stop), .fifo_deep(fifo_deep),
    .tx_half(tx_half), .baud_mode(baud_mode), .clk_sel(clk_sel),
    .break_on(break_on), .brk_chg(brk_chg)
  );

  always begin
    @(negedge clk);
    #2;
    if (rd_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] e);
    #1;
    n_run++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic push(input logic [7:0] b, input logic pe, input logic fe, input logic bk);
    @(negedge clk); rx_push = 1; rx_byte = b; rx_perr = pe; rx_ferr = fe; rx_break = bk;
    @(negedge clk); rx_push = 0; rx_perr = 0; rx_ferr = 0; rx_break = 0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state (R7, R2)
    rd(3'd1, 8'h08, "R7 reset status");
    chk("R2 reset rx_enabled", {7'b0, rx_enabled}, 8'h00);
    chk("R2 reset tx_enabled", {7'b0, tx_enabled}, 8'h00);
    wr(3'd2, 8'h05);
    chk("R2 rx enable", {7'b0, rx_enabled}, 8'h01);
    rd(3'd1, 8'h0C, "R7 enabled status");
    // mode pointer R3, R4, R5
    wr(3'd0, 8'h13);
    chk("R4 data_bits", {6'b0, data_bits}, 8'h03);
    chk("R4 parity none", {5'b0, parity_sel}, 8'h04);
    wr(3'd0, 8'h0F);
    chk("R5 two stop", {7'b0, two_stop}, 8'h01);
    wr(3'd0, 8'h07);
    chk("R5 one stop", {7'b0, two_stop}, 8'h00);
    chk("R3 MR1 kept after MR2 writes", {6'b0, data_bits}, 8'h03);
    wr(3'd2, 8'h10);
    rd(3'd0, 8'h13, "R3 readback MR1");
    rd(3'd0, 8'h07, "R3 readback MR2");
    rd(3'd0, 8'h07, "R3 pointer parks at MR2");
    // R6
    wr(3'd2, 8'hB0);
    wr(3'd0, 8'h1D);
    chk("R6 fifo_deep", {7'b0, fifo_deep}, 8'h01);
    chk("R6 tx_half", {7'b0, tx_half}, 8'h01);
    chk("R6 baud_mode", {5'b0, baud_mode}, 8'h05);
    wr(3'd0, 8'h04);
    chk("R3 MR0 then MR1 parity", {5'b0, parity_sel}, 8'h01);
    chk("R3 MR0 then MR1 bits", {6'b0, data_bits}, 8'h00);
    // R1
    wr(3'd1, 8'hBB);
    chk("R1 clk_sel", clk_sel, 8'hBB);
    rd(3'd1, 8'h0C, "R1 status after clk select");
    // R8, R9
    push(8'hA1, 0, 0, 0);
    push(8'hB2, 0, 0, 0);
    push(8'hC3, 0, 0, 0);
    rd(3'd1, 8'h0F, "R8 fifo full");
    push(8'hD4, 0, 0, 0);
    rd(3'd1, 8'h1F, "R9 overrun");
    rd(3'd3, 8'hA1, "R8 order 1");
    rd(3'd3, 8'hB2, "R8 order 2");
    rd(3'd3, 8'hC3, "R9 dropped byte absent");
    rd(3'd3, 8'h00, "R1 empty read");
    rd(3'd1, 8'h1C, "R9 overrun sticky");
    wr(3'd2, 8'h40);
    rd(3'd1, 8'h0C, "R9 overrun cleared");
    // R10, R11
    push(8'h11, 1, 0, 0);
    push(8'h22, 0, 1, 0);
    rd(3'd1, 8'h6D, "R10 parity and framing");
    wr(3'd2, 8'h20);
    rd(3'd1, 8'h6C, "R11 rx reset keeps errors");
    push(8'h33, 0, 0, 1);
    rd(3'd1, 8'hED, "R10 break flag");
    wr(3'd2, 8'h40);
    rd(3'd1, 8'h0D, "R10 errors cleared");
    rd(3'd3, 8'h33, "R10 byte kept");
    // R8 disabled, R2 disable wins
    wr(3'd2, 8'h02);
    push(8'h55, 0, 0, 0);
    rd(3'd1, 8'h0C, "R8 disabled receiver ignores push");
    wr(3'd2, 8'h01);
    wr(3'd2, 8'h03);
    chk("R2 disable wins", {7'b0, rx_enabled}, 8'h00);
    // R12
    chk("R12 break change set", {7'b0, brk_chg}, 8'h01);
    wr(3'd2, 8'h50);
    chk("R12 break change cleared", {7'b0, brk_chg}, 8'h00);
    wr(3'd2, 8'h60);
    chk("R12 break start", {7'b0, break_on}, 8'h01);
    wr(3'd2, 8'h70);
    chk("R12 break stop", {7'b0, break_on}, 8'h00);
    // R13, R11
    wr(3'd3, 8'h5A);
    chk("R13 tx_valid", {7'b0, tx_valid}, 8'h01);
    chk("R13 tx_data", tx_data, 8'h5A);
    rd(3'd1, 8'h00, "R13 status busy");
    wr(3'd3, 8'h77);
    chk("R13 write while busy ignored", tx_data, 8'h5A);
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
    chk("R13 pop", {7'b0, tx_valid}, 8'h00);
    rd(3'd1, 8'h0C, "R13 status after pop");
    wr(3'd3, 8'h66);
    wr(3'd2, 8'h30);
    chk("R11 tx reset", {7'b0, tx_valid}, 8'h00);
    rd(3'd1, 8'h0C, "R11 tx reset status");
    wr(3'd2, 8'h08);
    chk("R2 tx disabled", {7'b0, tx_enabled}, 8'h00);
    wr(3'd3, 8'h44);
    chk("R13 disabled tx ignores write", {7'b0, tx_valid}, 8'h00);
    rd(3'd1, 8'h08, "R7 tx disabled status");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule